// File: doc/BRIEF.md
# Buffered SPI Master Transceiver

This block is the master side of a synchronous serial link. Software talks to it through a small word-wide register port. Writing a word to the transmit register starts a transfer. During that transfer the block shifts the word out on a serial data line, most significant bit first, and at the same time collects the same number of bits from the return data line.

The transmit side and the receive side each have one buffer entry, in front of a single shift register. Software can therefore queue the next word while the current one is still on the wire. If the next word is waiting when a word finishes, it moves straight into the shifter and the serial clock continues without a pause. The word length (1 to 16 bits) and the serial clock rate come from a control register.

Four status flags report the state of the block: transmit buffer empty, receive buffer full, transfer finished and receive overrun. Each flag has its own interrupt enable. Slave select is not part of this block; a separate general-purpose output drives it.

Top module: `spi_buf_master`

## Requirements
- R1: After reset the status register (address 3) reads 0x0001: transmit-empty is 1 and the other flags are 0. The serial clock, serial data out and irq are all 0.
- R2: A word is clocked with exactly L+1 rising serial-clock edges, where L is control-register bits [3:0] (address 0). The clock idles low. Each clock half lasts H+1 system cycles, where H is control bits [15:8].
- R3: Serial data out carries the transmit word, most significant of its L+1 bits first. It changes only while the serial clock is low. The input line is sampled on each rising serial-clock edge.
- R4: When a word completes, the received bits land in bits [L:0] of the receive register (address 2), the first received bit being the most significant. The upper bits read as zero. Receive-full (status bit 1) becomes 1.
- R5: A read of the receive register clears receive-full.
- R6: If a word completes while receive-full is already 1 and no receive read happens in that cycle, the receive register is overwritten and overrun (status bit 3) becomes 1. If a receive read falls in the completion cycle, the read returns the older word, overrun stays 0 and receive-full stays 1 with the new word.
- R7: A write to the transmit register (address 1) clears transmit-empty (status bit 0). Transmit-empty returns to 1 when the word moves into the shifter. A transmit write while transmit-empty is 0 is ignored.
- R8: If a word is waiting in the transmit buffer when the current word completes, it starts at once. Rising serial-clock edges then stay evenly spaced, 2·(H+1) system cycles apart, across the word boundary.
- R9: Transfer-end (status bit 2) becomes 1 when a word completes with the transmit buffer empty. Writing status with bit 2 set clears transfer-end. Writing status with bit 3 set clears overrun.
- R10: irq is the OR of each status flag ANDed with its enable. The enables are control bits 4 (transmit-empty), 5 (receive-full), 6 (transfer-end) and 7 (overrun).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select: 0 control, 1 transmit, 2 receive, 3 status |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe (has a side effect only on the receive register) |
| reg_rdata | output | 16 | Read data for the selected register |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_sdo | output | 1 | Serial data out |
| spi_sdi | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same system cycle: a software read of the receive register and the completion of the next word. The bench provokes this collision on purpose. It queues two words back to back and waits for the last rising serial-clock edge of the second word. It then raises the read strobe exactly H+1 cycles later, so the read coincides with the falling edge that finishes the word. The collision is judged correct when the read returns the first word, overrun stays clear, receive-full stays set, and a following read returns the second word.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int unsigned WORD_W = 16;
  localparam int unsigned LEN_W  = 4;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LEN_W-1:0]  len_t;

  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_TXD  = 2'd1,
    RA_RXD  = 2'd2,
    RA_STAT = 2'd3
  } reg_addr_e;

  // Status bit order: bit0 tx empty, bit1 rx full, bit2 end, bit3 overrun
  typedef struct packed {
    logic ovr;
    logic tend;
    logic rbf;
    logic tbe;
  } stat_t;

  // Ones in bits [m1:0]
  function automatic word_t low_mask(len_t m1);
    word_t m;
    for (int i = 0; i < int'(WORD_W); i++) m[i] = (i <= int'(m1));
    return m;
  endfunction

  // Move bit m1 of w to the top of the word so it leaves first
  function automatic word_t msb_align(word_t w, len_t m1);
    len_t sh;
    sh = len_t'(WORD_W - 1) - m1;
    return w << sh;
  endfunction

endpackage

// File: rtl/spim_divider.sv
module spim_divider #(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_m1_i,
  output logic              tick_o
);

  logic [HALF_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_m1_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // Counter is parked at zero whenever the engine is idle
  p_idle_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  word_t load_word_i,
  input  len_t  load_len_i,
  input  logic  tick_i,
  input  logic  sdi_i,
  output logic  busy_o,
  output logic  sck_o,
  output logic  sdo_o,
  output logic  done_o,
  output word_t rx_word_o
);

  word_t shreg_q;
  len_t  len_q;
  len_t  bitcnt_q;
  logic  sck_q;
  logic  busy_q;
  logic  sdi_q;

  logic  rise_ev;
  logic  fall_ev;
  logic  last_bit;
  word_t shifted;

  assign rise_ev  = busy_q && tick_i && !sck_q;
  assign fall_ev  = busy_q && tick_i && sck_q;
  assign last_bit = (bitcnt_q == len_q);
  assign shifted  = {shreg_q[WORD_W-2:0], sdi_q};

  assign done_o    = fall_ev && last_bit;
  assign rx_word_o = shifted & low_mask(len_q);
  assign busy_o    = busy_q;
  assign sck_o     = sck_q;
  assign sdo_o     = busy_q & shreg_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      len_q    <= '0;
      bitcnt_q <= '0;
      sck_q    <= 1'b0;
      busy_q   <= 1'b0;
      sdi_q    <= 1'b0;
    end else if (load_i) begin
      shreg_q  <= msb_align(load_word_i, load_len_i);
      len_q    <= load_len_i;
      bitcnt_q <= '0;
      sck_q    <= 1'b0;
      busy_q   <= 1'b1;
    end else if (rise_ev) begin
      sck_q <= 1'b1;
      sdi_q <= sdi_i;
    end else if (fall_ev) begin
      sck_q   <= 1'b0;
      shreg_q <= shifted;
      if (last_bit) busy_q   <= 1'b0;
      else          bitcnt_q <= bitcnt_q + 1'b1;
    end
  end

  p_sck_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);

  p_bitcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bitcnt_q <= len_q));

  p_sdo_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(sdo_o));

endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
  import spim_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          reg_addr,
  input  logic                reg_wr,
  input  logic [WORD_W-1:0]   reg_wdata,
  input  logic                reg_rd,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic                spi_sck,
  output logic                spi_sdo,
  input  logic                spi_sdi,
  output logic                irq
);

  localparam int unsigned IE_LSB   = LEN_W;
  localparam int unsigned HALF_LSB = 8;

  // control fields
  len_t              cfg_len_q;
  logic [3:0]        cfg_ie_q;
  logic [HALF_W-1:0] cfg_half_q;

  // buffers and flags
  word_t txbuf_q;
  logic  tx_full_q;
  word_t rxbuf_q;
  logic  rbf_q;
  logic  tend_q;
  logic  ovr_q;
  stat_t stat;

  // named internal events
  logic  wr_ctrl, wr_tx, wr_stat, rx_rd;
  logic  load_ev;
  logic  eng_busy, eng_done, tick;
  word_t eng_rx;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_tx   = reg_wr && (reg_addr == RA_TXD);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign rx_rd   = reg_rd && (reg_addr == RA_RXD);
  assign load_ev = tx_full_q && (!eng_busy || eng_done);

  spim_divider #(.HALF_W(HALF_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (eng_busy),
    .half_m1_i (cfg_half_q),
    .tick_o    (tick)
  );

  spim_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_ev),
    .load_word_i (txbuf_q),
    .load_len_i  (cfg_len_q),
    .tick_i      (tick),
    .sdi_i       (spi_sdi),
    .busy_o      (eng_busy),
    .sck_o       (spi_sck),
    .sdo_o       (spi_sdo),
    .done_o      (eng_done),
    .rx_word_o   (eng_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_len_q  <= '0;
      cfg_ie_q   <= '0;
      cfg_half_q <= '0;
    end else if (wr_ctrl) begin
      cfg_len_q  <= reg_wdata[LEN_W-1:0];
      cfg_ie_q   <= reg_wdata[IE_LSB +: 4];
      cfg_half_q <= reg_wdata[HALF_LSB +: HALF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf_q   <= '0;
      tx_full_q <= 1'b0;
    end else if (load_ev) begin
      tx_full_q <= 1'b0;
    end else if (wr_tx && !tx_full_q) begin
      txbuf_q   <= reg_wdata;
      tx_full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf_q <= '0;
      rbf_q   <= 1'b0;
      ovr_q   <= 1'b0;
      tend_q  <= 1'b0;
    end else begin
      if (eng_done) rxbuf_q <= eng_rx;

      if (eng_done)   rbf_q <= 1'b1;
      else if (rx_rd) rbf_q <= 1'b0;

      if (eng_done && rbf_q && !rx_rd)  ovr_q <= 1'b1;
      else if (wr_stat && reg_wdata[3]) ovr_q <= 1'b0;

      if (eng_done && !tx_full_q)       tend_q <= 1'b1;
      else if (wr_stat && reg_wdata[2]) tend_q <= 1'b0;
    end
  end

  assign stat = '{ovr: ovr_q, tend: tend_q, rbf: rbf_q, tbe: !tx_full_q};
  assign irq  = |(stat & cfg_ie_q);

  always_comb begin
    case (reg_addr)
      RA_CTRL: begin
        reg_rdata = '0;
        reg_rdata[LEN_W-1:0]          = cfg_len_q;
        reg_rdata[IE_LSB +: 4]        = cfg_ie_q;
        reg_rdata[HALF_LSB +: HALF_W] = cfg_half_q;
      end
      RA_RXD:  reg_rdata = rxbuf_q;
      RA_STAT: reg_rdata = {{(WORD_W-4){1'b0}}, stat};
      default: reg_rdata = '0;
    endcase
  end

  p_tbe_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> stat.tbe);

  p_rbf_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> rbf_q);

  p_ovr_on_unread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && rbf_q && !rx_rd) |=> ovr_q);

  p_no_ovr_on_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && rx_rd && !ovr_q) |=> (!ovr_q && rbf_q));

  p_tend_on_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !tx_full_q) |=> tend_q);

endmodule

// File: tb/spi_buf_master_test.sv
module spi_buf_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_rdata;
  logic        spi_sck, spi_sdo, irq;
  logic        spi_sdi = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  spi_buf_master uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_sdo(spi_sdo), .spi_sdi(spi_sdi), .irq(irq)
  );

  // scoreboard state
  logic [15:0] exp_mosi[$];
  logic [15:0] resp_q[$];
  logic [15:0] exp_rx[$];
  int          s_len = 1;
  int          s_half = 0;
  int          s_cnt = 0;
  logic [15:0] s_mosi = '0;
  bit          gap_chk = 0;
  bit          prev_ok = 0;
  time         prev_rise = 0;
  event        word_end;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] msk(int len);
    logic [15:0] m;
    for (int i = 0; i < 16; i++) m[i] = (i < len);
    return m;
  endfunction

  // slave model / monitor: compares each shifted-out word, checks clock spacing
  always @(posedge spi_sck) begin
    if (gap_chk && prev_ok)
      chk("R8 rise spacing", 32'($time - prev_rise), 32'(8 * (s_half + 1)));
    prev_rise = $time;
    prev_ok   = 1;
    s_mosi = {s_mosi[14:0], spi_sdo};
    s_cnt++;
    if (s_cnt == s_len) begin
      if (exp_mosi.size() == 0) chk("R2 R3 unexpected word", 32'(s_mosi), 32'hFFFF_FFFF);
      else                      chk("R2 R3 sdo word", 32'(s_mosi), 32'(exp_mosi.pop_front()));
      if (resp_q.size() > 0) void'(resp_q.pop_front());
      s_cnt  = 0;
      s_mosi = '0;
      -> word_end;
    end
  end

  always @(negedge clk)
    spi_sdi = (resp_q.size() > 0) ? resp_q[0][s_len - 1 - s_cnt] : 1'b0;

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic cfg(int len_m1, logic [3:0] ie, int half);
    s_len  = len_m1 + 1;
    s_half = half;
    wr(2'd0, {8'(half), ie, 4'(len_m1)});
  endtask

  task automatic send(logic [15:0] tx, logic [15:0] resp);
    exp_mosi.push_back(tx & msk(s_len));
    resp_q.push_back(resp);
    exp_rx.push_back(resp & msk(s_len));
    wr(2'd1, tx);
  endtask

  task automatic read_rx(string req);
    logic [15:0] d;
    rd(2'd2, d);
    if (exp_rx.size() == 0) chk(req, 32'(d), 32'hFFFF_FFFF);
    else                    chk(req, 32'(d), 32'(exp_rx.pop_front()));
  endtask

  task automatic wait_tend();
    logic [15:0] d;
    d = '0;
    for (int i = 0; i < 5000 && !d[2]; i++) rd(2'd3, d);
  endtask

  task automatic stat_is(string req, logic [3:0] e);
    logic [15:0] d;
    rd(2'd3, d);
    chk(req, 32'(d), 32'(e));
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sck", 32'(spi_sck), 0);
    chk("R1 sdo", 32'(spi_sdo), 0);
    chk("R1 irq", 32'(irq), 0);
    stat_is("R1 status", 4'b0001);

    // single 8-bit word, R3 R4 R5 R9
    cfg(7, 4'h0, 1);
    send(16'h00A5, 16'h003C);
    wait_tend();
    stat_is("R4 R9 after word", 4'b0111);
    read_rx("R4 rx 8-bit");
    stat_is("R5 rbf cleared", 4'b0101);
    wr(2'd3, 16'h0004);
    stat_is("R9 tend cleared", 4'b0001);

    // 16-bit word, fastest clock
    cfg(15, 4'h0, 0);
    send(16'hC35A, 16'h9E21);
    wait_tend();
    read_rx("R4 rx 16-bit");
    wr(2'd3, 16'h0004);

    // 4-bit word, upper bits must read zero
    cfg(3, 4'h0, 2);
    send(16'hFFF6, 16'hFFFB);
    wait_tend();
    read_rx("R4 rx 4-bit upper zero");
    wr(2'd3, 16'h0004);

    // 1-bit word
    cfg(0, 4'h0, 1);
    send(16'h0001, 16'h0001);
    wait_tend();
    read_rx("R4 rx 1-bit");
    wr(2'd3, 16'h0004);

    // back-to-back words with an ignored write, R7 R8
    cfg(7, 4'h0, 3);
    prev_ok = 0;
    gap_chk = 1;
    send(16'h0011, 16'h00E1);
    send(16'h0022, 16'h00D2);
    stat_is("R7 tbe low while queued", 4'b0000);
    wr(2'd1, 16'h0033);            // must be ignored (R7)
    @(word_end);
    repeat (s_half + 3) @(negedge clk);
    read_rx("R8 rx word 1");
    send(16'h0044, 16'h00C3);
    @(word_end);
    repeat (s_half + 3) @(negedge clk);
    read_rx("R8 rx word 2");
    @(word_end);
    repeat (s_half + 3) @(negedge clk);
    read_rx("R8 rx word 3");
    gap_chk = 0;
    wait_tend();
    stat_is("R7 R8 end of burst", 4'b0101);
    chk("R7 ignored write not sent", 32'(exp_mosi.size()), 0);
    wr(2'd3, 16'h0004);

    // overrun, R6 R9
    send(16'h005A, 16'h0081);
    send(16'h007E, 16'h0042);
    wait_tend();
    stat_is("R6 overrun set", 4'b1111);
    void'(exp_rx.pop_front());
    read_rx("R6 rx overwritten");
    wr(2'd3, 16'h000C);
    stat_is("R9 ovr and tend cleared", 4'b0001);

    // read colliding with completion, R6
    send(16'h00A1, 16'h0015);
    send(16'h00B2, 16'h0026);
    @(word_end);
    @(word_end);
    repeat (s_half + 1) @(negedge clk);
    reg_addr = 2'd2; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
    chk("R6 collide read old word", 32'(d), 32'(exp_rx.pop_front()));
    stat_is("R6 collide no overrun", 4'b0111);
    read_rx("R6 collide new word kept");
    wr(2'd3, 16'h0004);

    // interrupt gating, R10
    cfg(7, 4'b0001, 1);
    @(negedge clk);
    chk("R10 irq tbe", 32'(irq), 1);
    cfg(7, 4'b0010, 1);
    @(negedge clk);
    chk("R10 irq masked", 32'(irq), 0);
    send(16'h0055, 16'h00AA);
    wait_tend();
    chk("R10 irq rbf", 32'(irq), 1);
    read_rx("R10 rx");
    @(negedge clk);
    chk("R10 irq after read", 32'(irq), 0);
    cfg(7, 4'b0100, 1);
    @(negedge clk);
    chk("R10 irq tend", 32'(irq), 1);
    wr(2'd3, 16'h0004);
    @(negedge clk);
    chk("R10 irq tend cleared", 32'(irq), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule